// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single countdown timer attached to a small 32-bit register bus made of an address, a write strobe, write data and combinational read data. Software programs a reload value and a control byte. The counter then steps down by one on each prescaled tick. When it reaches zero it raises a sticky status flag, and that flag can drive a level interrupt line.

The control byte selects the following:

- a counter width of 16 or 32 bits;
- a prescaler of 1, 16 or 256;
- what happens at zero: wrap to all-ones (free-running), wrap to the programmed value (periodic), or stop (one-shot).

Two registers hold the reload value. One also restarts the counter at once. The other changes only the value used at the next wrap.

Address bits [1:0] are ignored. The word index is `bus_addr[ADDR_W-1:2]`:

| Word | Register |
|---|---|
| 0 | reload, immediate |
| 1 | count, read-only |
| 2 | control |
| 3 | flag clear |
| 4 | raw flag |
| 5 | masked flag |
| 6 | reload, deferred |

The control byte sits in bits [7:0]:

| Bit | Meaning |
|---|---|
| 0 | stop-at-zero |
| 1 | 32-bit width |
| 3:2 | prescale code |
| 5 | flag-to-pin enable |
| 6 | wrap to the programmed value |
| 7 | run |

Top module: `ival_timer`

## Requirements
- R1: One cycle after the internal reset is released, the registers read as follows: control 0x20, count 0, raw flag 0, reload 0, and `irq_o` is low.
- R2: A write to word 0 stores the full 32-bit reload value. In the same edge the count is loaded with that value masked to the active width. If a tick falls in the same cycle, the write wins. Words 0 and 6 both read back the stored reload value.
- R3: A write to word 6 stores the reload value and leaves the count unchanged. The new value is used only at the next wrap.
- R4: While bit 7 is set, each tick decrements the count. Prescale code 1 gives one tick per 16 enabled cycles, code 2 one per 256, and codes 0 and 3 one per cycle. Any control write, and any cycle with bit 7 clear, returns the prescaler phase to zero. The first tick after that comes on the Nth enabled cycle.
- R5: With bits 6 and 0 clear, a tick at count 0 reloads the count with 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode.
- R6: With bit 6 set and bit 0 clear, a tick at count 0 reloads the count with the stored reload value masked to the active width.
- R7: With bit 0 set, a tick at count 0 leaves the count at 0. Bit 7 keeps its written value.
- R8: A tick at count 1, with no word-0 write in the same cycle, sets the raw flag (word 4, bit 0). If a clear write lands in the same cycle, the set wins.
- R9: Any write to word 3 clears the raw flag, unless the flag is being set in the same cycle.
- R10: Word 5 bit 0 reads as the raw flag AND control bit 5, and `irq_o` always equals that value.
- R11: Writes to word 1 and to unmapped words have no effect. Reads of word 3 and of unmapped words return 0.
- R12: A write to word 2 stores `bus_wdata[7:0]`. Word 2 reads that byte back with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Masked level interrupt |

## Verification
The hardest case to reach is a flag-clear write in exactly the cycle where a tick takes the count from 1 to 0. A directed sequence gets there by loading a small value with the divider at 1 and counting cycles, so that the clear write lands on that tick. Deferred reload is checked the same way: after a word-6 write, the bench watches the count over a full period until the new value appears at the wrap. A slow-divider run confirms the 256-cycle tick spacing. Random traffic, biased towards small reload values and enabled control bytes, then mixes control writes into running counts so that prescaler phase restarts and mode changes happen at arbitrary points.

// File: rtl/ival_timer_pkg.sv
package ival_timer_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned PRE_W    = 8;

  localparam int unsigned WORD_RELOAD   = 0;
  localparam int unsigned WORD_COUNT    = 1;
  localparam int unsigned WORD_CONTROL  = 2;
  localparam int unsigned WORD_FLAG_CLR = 3;
  localparam int unsigned WORD_RAW      = 4;
  localparam int unsigned WORD_MASKED   = 5;
  localparam int unsigned WORD_DEFER    = 6;

  typedef struct packed {
    logic       run;
    logic       wrap_prog;
    logic       flag_en;
    logic       spare;
    logic [1:0] psel;
    logic       wide;
    logic       stop_zero;
  } tmr_ctrl_t;

  localparam tmr_ctrl_t CTRL_RESET = '{run: 1'b0, wrap_prog: 1'b0, flag_en: 1'b1,
                                       spare: 1'b0, psel: 2'd0, wide: 1'b0,
                                       stop_zero: 1'b0};

  function automatic logic [DATA_W-1:0] width_mask(input logic wide);
    width_mask = wide ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  endfunction

endpackage

// File: rtl/ival_decode.sv
module ival_decode
  import ival_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  tmr_ctrl_t         ctrl_q,
  input  logic [DATA_W-1:0] reload_q,
  input  logic [DATA_W-1:0] cnt_q,
  input  logic              raw_q,
  output logic              wr_reload,
  output logic              wr_defer,
  output logic              wr_ctrl,
  output logic              wr_clr,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;

  assign word = bus_addr[ADDR_W-1:2];

  always_comb begin
    wr_reload = bus_wr && (word == WORD_W'(WORD_RELOAD));
    wr_defer  = bus_wr && (word == WORD_W'(WORD_DEFER));
    wr_ctrl   = bus_wr && (word == WORD_W'(WORD_CONTROL));
    wr_clr    = bus_wr && (word == WORD_W'(WORD_FLAG_CLR));
  end

  always_comb begin
    bus_rdata = '0;
    if (word == WORD_W'(WORD_RELOAD) || word == WORD_W'(WORD_DEFER)) begin
      bus_rdata = reload_q;
    end else if (word == WORD_W'(WORD_COUNT)) begin
      bus_rdata = cnt_q;
    end else if (word == WORD_W'(WORD_CONTROL)) begin
      bus_rdata = {{(DATA_W-8){1'b0}}, ctrl_q};
    end else if (word == WORD_W'(WORD_RAW)) begin
      bus_rdata = {{(DATA_W-1){1'b0}}, raw_q};
    end else if (word == WORD_W'(WORD_MASKED)) begin
      bus_rdata = {{(DATA_W-1){1'b0}}, raw_q & ctrl_q.flag_en};
    end
  end

endmodule

// File: rtl/ival_prescaler.sv
module ival_prescaler
  import ival_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       tick
);

  localparam logic [PRE_W-1:0] LIM_DIV16  = PRE_W'(15);
  localparam logic [PRE_W-1:0] LIM_DIV256 = PRE_W'(255);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] phase_d;
  logic [PRE_W-1:0] limit;

  always_comb begin
    unique case (psel)
      2'd1:    limit = LIM_DIV16;
      2'd2:    limit = LIM_DIV256;
      default: limit = '0;
    endcase
  end

  assign tick = run && (phase_q == limit);

  always_comb begin
    if (restart || !run || tick) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/ival_counter.sv
module ival_counter
  import ival_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_reload,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] reload_q,
  input  tmr_ctrl_t         ctrl_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              hit_zero
);

  logic [DATA_W-1:0] cnt_d;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] wrap_val;
  logic              at_zero;

  assign mask    = width_mask(ctrl_q.wide);
  assign at_zero = (cnt_q == '0);

  assign hit_zero = tick && !wr_reload && (cnt_q == DATA_W'(1));

  always_comb begin
    if (ctrl_q.wrap_prog) begin
      wrap_val = reload_q & mask;
    end else begin
      wrap_val = mask;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (wr_reload) begin
      cnt_d = wdata & mask;
    end else if (tick) begin
      if (at_zero) begin
        if (!ctrl_q.stop_zero) begin
          cnt_d = wrap_val;
        end
      end else begin
        cnt_d = (cnt_q - DATA_W'(1)) & mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ival_regs.sv
module ival_regs
  import ival_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_reload,
  input  logic              wr_defer,
  input  logic              wr_ctrl,
  input  logic              wr_clr,
  input  logic              hit_zero,
  input  logic [DATA_W-1:0] wdata,
  output tmr_ctrl_t         ctrl_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              raw_q
);

  tmr_ctrl_t         ctrl_d;
  logic [DATA_W-1:0] reload_d;
  logic              raw_d;
  logic              reload_en;

  assign reload_en = wr_reload || wr_defer;

  always_comb begin
    ctrl_d   = wr_ctrl ? tmr_ctrl_t'(wdata[7:0]) : ctrl_q;
    reload_d = reload_en ? wdata : reload_q;
    if (hit_zero) begin
      raw_d = 1'b1;
    end else if (wr_clr) begin
      raw_d = 1'b0;
    end else begin
      raw_d = raw_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      reload_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      raw_q    <= raw_d;
    end
  end

endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  logic              rst_meta_n;
  logic              rst_sync_n;
  tmr_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] cnt_q;
  logic              raw_q;
  logic              wr_reload;
  logic              wr_defer;
  logic              wr_ctrl;
  logic              wr_clr;
  logic              tick;
  logic              hit_zero;

  // Reset asserts at once and releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ival_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .cnt_q     (cnt_q),
    .raw_q     (raw_q),
    .wr_reload (wr_reload),
    .wr_defer  (wr_defer),
    .wr_ctrl   (wr_ctrl),
    .wr_clr    (wr_clr),
    .bus_rdata (bus_rdata)
  );

  ival_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (ctrl_q.run),
    .restart (wr_ctrl),
    .psel    (ctrl_q.psel),
    .tick    (tick)
  );

  ival_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .wr_reload (wr_reload),
    .wdata     (bus_wdata),
    .reload_q  (reload_q),
    .ctrl_q    (ctrl_q),
    .cnt_q     (cnt_q),
    .hit_zero  (hit_zero)
  );

  ival_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_reload (wr_reload),
    .wr_defer  (wr_defer),
    .wr_ctrl   (wr_ctrl),
    .wr_clr    (wr_clr),
    .hit_zero  (hit_zero),
    .wdata     (bus_wdata),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .raw_q     (raw_q)
  );

  assign irq_o = raw_q & ctrl_q.flag_en;

endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_o,
  input logic [31:0]       cnt_q,
  input logic              raw_q,
  input logic [7:0]        ctrl_q,
  input logic              tick
);

  logic [ADDR_W-3:0] word;
  logic              ld_wr;

  assign word  = bus_addr[ADDR_W-1:2];
  assign ld_wr = bus_wr && (word == '0);

  p_load_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> cnt_q == ($past(ctrl_q[1]) ? $past(bus_wdata) : {16'h0, $past(bus_wdata[15:0])}));

  p_free_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == 32'd0 && !ctrl_q[0] && !ctrl_q[6] && !ld_wr)
    |=> cnt_q == ($past(ctrl_q[1]) ? 32'hFFFF_FFFF : 32'h0000_FFFF));

  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && cnt_q == 32'd0 && !ld_wr) |=> cnt_q == 32'd0);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == 32'd1 && !ld_wr) |=> raw_q);

  p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == 3 && !(tick && cnt_q == 32'd1)) |=> !raw_q);

  p_pin_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && word == 5) |-> bus_rdata[0] == irq_o);

  p_count_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == 1 && !tick) |=> $stable(cnt_q));

endmodule

bind ival_timer ival_timer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .cnt_q     (cnt_q),
  .raw_q     (raw_q),
  .ctrl_q    (ctrl_q),
  .tick      (tick)
);

// File: tb/ival_timer_tb_top.sv
module ival_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk;
  int n_bad;
  bit done;

  // Reference state, derived from the requirements.
  logic [7:0]  m_ctrl;
  logic [31:0] m_reload;
  logic [31:0] m_val;
  logic        m_raw;
  int          m_pc;

  ival_timer #(.ADDR_W(6)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a[5:2])
      4'd0, 4'd6: m_read = m_reload;
      4'd1:       m_read = m_val;
      4'd2:       m_read = {24'h0, m_ctrl};
      4'd4:       m_read = {31'h0, m_raw};
      4'd5:       m_read = {31'h0, m_raw & m_ctrl[5]};
      default:    m_read = 32'h0;
    endcase
  endfunction

  function automatic string tag_for(input logic [5:0] a);
    case (a[5:2])
      4'd0:    tag_for = "R2";
      4'd1:    tag_for = "R4";
      4'd2:    tag_for = "R12";
      4'd4:    tag_for = "R8";
      4'd5:    tag_for = "R10";
      4'd6:    tag_for = "R3";
      default: tag_for = "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic m_step(input logic wr, input logic [5:0] a, input logic [31:0] d);
    int          div;
    logic        tk, ldw, bgw, cw, clr, hit;
    logic [31:0] mask;
    div  = (m_ctrl[3:2] == 2'd1) ? 16 : (m_ctrl[3:2] == 2'd2) ? 256 : 1;
    tk   = m_ctrl[7] && (m_pc == div - 1);
    mask = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    ldw  = wr && a[5:2] == 4'd0;
    bgw  = wr && a[5:2] == 4'd6;
    cw   = wr && a[5:2] == 4'd2;
    clr  = wr && a[5:2] == 4'd3;
    hit  = tk && !ldw && m_val == 32'd1;
    m_pc = (cw || !m_ctrl[7] || tk) ? 0 : m_pc + 1;
    if (ldw) m_val = d & mask;
    else if (tk) begin
      if (m_val == 32'd0) begin
        if (!m_ctrl[0]) m_val = m_ctrl[6] ? (m_reload & mask) : mask;
      end else m_val = (m_val - 32'd1) & mask;
    end
    if (hit) m_raw = 1'b1;
    else if (clr) m_raw = 1'b0;
    if (ldw || bgw) m_reload = d;
    if (cw) m_ctrl = d[7:0];
  endtask

  task automatic cyc(input logic wr, input logic [5:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    check((tag == "") ? tag_for(a) : tag, bus_rdata, m_read(a));
    check("R10", {31'h0, irq_o}, {31'h0, m_raw & m_ctrl[5]});
    m_step(wr, a, d);
  endtask

  task automatic watch(input logic [5:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0, tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [5:0]  a;
    logic        w;
    n_chk = 0; n_bad = 0; done = 0;
    void'($urandom(32'd20511));
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; rst_n = 0;
    m_ctrl = 8'h20; m_reload = 0; m_val = 0; m_raw = 0; m_pc = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state
    cyc(0, 6'h08, 0, "R1"); cyc(0, 6'h04, 0, "R1");
    cyc(0, 6'h10, 0, "R1"); cyc(0, 6'h00, 0, "R1");
    // R12 control readback, R6 periodic wrap
    cyc(1, 6'h00, 32'd5, "R2");
    cyc(1, 6'h08, 32'h0000_01E0, "R12");
    cyc(0, 6'h08, 0, "R12");
    watch(6'h04, 14, "R6");
    cyc(0, 6'h10, 0, "R8");
    cyc(1, 6'h0C, 0, "R9"); cyc(0, 6'h10, 0, "R9");
    // R11 ignored writes and unmapped reads
    cyc(1, 6'h04, 32'd1234, "R11"); cyc(0, 6'h04, 0, "R11");
    cyc(1, 6'h3C, 32'hFFFF_FFFF, "R11"); cyc(0, 6'h1C, 0, "R11");
    cyc(0, 6'h0C, 0, "R11"); cyc(0, 6'h08, 0, "R11");
    // R3 deferred reload
    cyc(1, 6'h18, 32'd2, "R3"); cyc(0, 6'h00, 0, "R3");
    watch(6'h04, 12, "R3");
    // R5 free-running wrap, 16 and 32 bit
    cyc(1, 6'h08, 32'hA0, "R5"); cyc(1, 6'h00, 32'd2, "R5");
    watch(6'h04, 5, "R5");
    cyc(1, 6'h08, 32'hA2, "R5"); cyc(1, 6'h00, 32'd1, "R5");
    watch(6'h04, 4, "R5");
    // R7 stop at zero
    cyc(1, 6'h08, 32'hE1, "R7"); cyc(1, 6'h00, 32'd3, "R7");
    watch(6'h04, 8, "R7"); cyc(0, 6'h08, 0, "R7");
    // R4 divide by 16 and 256, code 3
    cyc(1, 6'h08, 32'hE4, "R4"); cyc(1, 6'h00, 32'd2, "R4");
    watch(6'h04, 60, "R4");
    cyc(1, 6'h08, 32'hE8, "R4"); cyc(1, 6'h00, 32'd1, "R4");
    watch(6'h04, 600, "R4");
    cyc(1, 6'h08, 32'hEC, "R4"); watch(6'h04, 6, "R4");
    // R10 masked status with enable off
    cyc(1, 6'h08, 32'hC0, "R10"); cyc(1, 6'h00, 32'd1, "R10");
    watch(6'h14, 4, "R10"); cyc(0, 6'h10, 0, "R10");
    // R8 set wins over clear in the same cycle
    cyc(1, 6'h0C, 0, "R9");
    cyc(1, 6'h08, 32'hE0, "R8"); cyc(1, 6'h00, 32'd3, "R8");
    cyc(0, 6'h04, 0, "R8"); cyc(0, 6'h04, 0, "R8");
    cyc(1, 6'h0C, 0, "R8"); cyc(0, 6'h10, 0, "R8");
    // R2 load wins over tick, 16-bit masking
    cyc(1, 6'h00, 32'h0012_0007, "R2"); cyc(0, 6'h04, 0, "R2"); cyc(0, 6'h18, 0, "R2");

    // Random traffic
    for (int i = 0; i < 30000; i++) begin
      w = ($urandom % 10) < 3;
      case ($urandom % 9)
        0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h08; 3: a = 6'h0C;
        4: a = 6'h10; 5: a = 6'h14; 6: a = 6'h18; 7: a = 6'h24;
        default: a = 6'h04;
      endcase
      d = $urandom;
      if (a == 6'h08) begin
        d[7] = ($urandom % 5) != 0;
        if ($urandom % 8 != 0) d[3:2] = 2'd0;
        if ($urandom % 4 != 0) d[0] = 1'b0;
      end else if ((a == 6'h00 || a == 6'h18) && ($urandom % 10 != 0)) begin
        d = $urandom % 40;
      end
      cyc(w, a, d, "");
    end

    done = 1;
    finish_run();
  end

endmodule